// File: doc/BRIEF.md
# Biphase Mark Coded Transmit Serializer

This block produces the serial half-bit cell stream for one Biphase Mark Coded packet. A packet starts with a one-cycle start pulse. The block first sends a fixed alternating training sequence. It then draws pre-encoded 10-cell symbol words from an upstream source over a valid/ready handshake. Before it sends each word it inverts the word when needed, so that the line level carries on without a break from the previous cell. It finishes with a pair of closing cells that leave the line resting low.

Cells advance only on a one-cycle clock enable, `cellTick`, which the surrounding logic pulses at twice the data rate (600 kHz for a 300 kHz bit rate). The upstream logic marks the final symbol of the packet with `symLast`. If the upstream logic has no symbol ready at the moment one is needed, the block reports an underrun and closes the packet early.

Top module: `bmc_tx_serializer`

## Requirements
- R1: After an accepted `startPkt`, the first 128 cells on `txCell` are the 32-bit pattern 0xB4B4B4B4 repeated four times, least significant bit first. The first of these cells is 0 and the last is 1.
- R2: The first symbol after the training sequence is sent as the bitwise inverse of `symData`, because the sequence leaves the line high.
- R3: Each later symbol is sent inverted if bit 9 of the previously transmitted (post-inversion) word was 1, and sent unchanged otherwise.
- R4: Each word is sent cell 0 first, one cell per `cellTick`. `txCell` changes only in the clock edge that follows a cycle with `cellTick` high.
- R5: After the last cell of a symbol flagged by `symLast`, two closing cells follow. If the line was last low they are 1 then 0. If it was last high they are 0 then 0. While `busy` is low, `txCell` is 0.
- R6: `symReady` is high only in a cycle where `cellTick` is high and a new symbol is needed. A word is taken when `symValid` and `symReady` are both high.
- R7: `busy` rises on the clock edge that accepts `startPkt` while idle. It falls one tick after the final closing cell. `startPkt` has no effect while `busy` is high.
- R8: `pktDone` is high for exactly one clock, in the cycle after `busy` falls.
- R9: If `symValid` is low when a symbol is needed, `underrun` pulses for one clock. In the same tick the first closing cell is emitted, chosen as in R5, and a 0 cell follows on the next tick.
- R10: During and right after reset, `txCell`, `busy`, `pktDone`, `symReady` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellTick | input | 1 | One-cycle enable, one pulse per half-bit cell |
| startPkt | input | 1 | Starts a packet when the block is idle |
| symValid | input | 1 | Upstream symbol word is valid |
| symData | input | 10 | Pre-encoded 10-cell symbol word, cell 0 in bit 0 |
| symLast | input | 1 | Marks the final symbol of the packet |
| symReady | output | 1 | Symbol is taken this cycle if valid |
| txCell | output | 1 | Serial cell level driven to the line |
| busy | output | 1 | Packet in progress |
| pktDone | output | 1 | One-clock pulse after the packet ends |
| underrun | output | 1 | One-clock pulse when a needed symbol was missing |

## Verification
Two events can land on the same tick:
- the point where a new symbol is needed, and
- the decision to close the packet.

When `symValid` is withheld at that point, the underrun flag and the first closing cell must appear on the same edge, and the closing cell must follow the line level left by the last symbol. The bench provokes this in two places: right after the training sequence, and after two symbols that carry no last flag. The same collision, without the underrun, occurs when the final cell of a `symLast` word is followed by the closing edge. A behavioural reference model built on a cell queue predicts every output on every clock. It checks both the level and the cycle of each cell, the ready strobe, `busy`, `pktDone` and `underrun`.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYM,
    ST_EDGE,
    ST_LOW,
    ST_FIN
  } txState_t;

  // strobes from control to datapath, each valid only on a cell tick
  typedef struct packed {
    logic emitPre;
    logic loadSym;
    logic shiftCell;
    logic closeEdge;
    logic closeLow;
  } txStrobes_t;

endpackage

// File: rtl/bmc_tx_ctrl.sv
module bmc_tx_ctrl
  import bmc_tx_pkg::*;
#(
  parameter int PRE_CELLS = 128,
  parameter int PAT_W     = 32,
  parameter int SYM_CELLS = 10,
  localparam int PRE_CNT_W = $clog2(PRE_CELLS),
  localparam int PAT_IDX_W = $clog2(PAT_W),
  localparam int SYM_CNT_W = $clog2(SYM_CELLS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cellTick,
  input  logic                 startPkt,
  input  logic                 symValid,
  input  logic                 symLast,
  output logic                 symReady,
  output txStrobes_t           strobes,
  output logic [PAT_IDX_W-1:0] preIdx,
  output logic                 busy,
  output logic                 pktDone,
  output logic                 underrun
);

  txState_t stateQ, stateD;
  logic [PRE_CNT_W-1:0] preCntQ, preCntD;
  logic [PAT_IDX_W-1:0] patIdxQ, patIdxD;
  logic [SYM_CNT_W-1:0] cellCntQ, cellCntD;
  logic lastQ, lastD;
  logic finQ, finD;
  logic underQ, underD;
  logic doneQ;
  logic needSym;

  assign needSym  = (stateQ == ST_SYM) && (cellCntQ == '0);
  assign symReady = needSym && cellTick;
  assign preIdx   = patIdxQ;
  assign busy     = (stateQ != ST_IDLE);
  assign pktDone  = doneQ;
  assign underrun = underQ;

  always_comb begin
    stateD   = stateQ;
    preCntD  = preCntQ;
    patIdxD  = patIdxQ;
    cellCntD = cellCntQ;
    lastD    = lastQ;
    finD     = 1'b0;
    underD   = 1'b0;
    strobes  = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startPkt) begin
          stateD  = ST_PRE;
          preCntD = '0;
          patIdxD = '0;
          lastD   = 1'b0;
        end
      end
      ST_PRE: begin
        if (cellTick) begin
          strobes.emitPre = 1'b1;
          preCntD = preCntQ + 1'b1;
          patIdxD = (patIdxQ == PAT_IDX_W'(PAT_W - 1)) ? '0 : patIdxQ + 1'b1;
          if (preCntQ == PRE_CNT_W'(PRE_CELLS - 1)) begin
            stateD   = ST_SYM;
            cellCntD = '0;
          end
        end
      end
      ST_SYM: begin
        if (cellTick) begin
          if (cellCntQ == '0) begin
            if (symValid) begin
              strobes.loadSym = 1'b1;
              cellCntD = SYM_CNT_W'(SYM_CELLS - 1);
              lastD    = symLast;
            end else begin
              strobes.closeEdge = 1'b1;
              underD = 1'b1;
              stateD = ST_LOW;
            end
          end else begin
            strobes.shiftCell = 1'b1;
            cellCntD = cellCntQ - 1'b1;
            if ((cellCntQ == SYM_CNT_W'(1)) && lastQ) stateD = ST_EDGE;
          end
        end
      end
      ST_EDGE: begin
        if (cellTick) begin
          strobes.closeEdge = 1'b1;
          stateD = ST_LOW;
        end
      end
      ST_LOW: begin
        if (cellTick) begin
          strobes.closeLow = 1'b1;
          stateD = ST_FIN;
        end
      end
      ST_FIN: begin
        if (cellTick) begin
          stateD = ST_IDLE;
          finD   = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      preCntQ  <= '0;
      patIdxQ  <= '0;
      cellCntQ <= '0;
      lastQ    <= 1'b0;
      finQ     <= 1'b0;
      underQ   <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stateQ   <= stateD;
      preCntQ  <= preCntD;
      patIdxQ  <= patIdxD;
      cellCntQ <= cellCntD;
      lastQ    <= lastD;
      finQ     <= finD;
      underQ   <= underD;
      doneQ    <= finQ;
    end
  end

endmodule

// File: rtl/bmc_tx_datapath.sv
module bmc_tx_datapath
  import bmc_tx_pkg::*;
#(
  parameter int          PAT_W       = 32,
  parameter logic [31:0] PRE_PATTERN = 32'hB4B4_B4B4,
  parameter int          SYM_CELLS   = 10,
  localparam int PAT_IDX_W = $clog2(PAT_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strobes,
  input  logic [PAT_IDX_W-1:0] preIdx,
  input  logic [SYM_CELLS-1:0] symData,
  output logic                 txCell
);

  logic                 cellQ;
  logic                 lineHighQ;
  logic [SYM_CELLS-2:0] shiftQ;
  logic [SYM_CELLS-1:0] encWord;
  logic                 preBit;

  // polarity mask applied cell by cell
  for (genvar g = 0; g < SYM_CELLS; g++) begin : gEnc
    assign encWord[g] = symData[g] ^ lineHighQ;
  end

  assign preBit = PRE_PATTERN[preIdx];
  assign txCell = cellQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellQ     <= 1'b0;
      lineHighQ <= 1'b0;
      shiftQ    <= '0;
    end else if (strobes.emitPre) begin
      cellQ     <= preBit;
      lineHighQ <= preBit;
    end else if (strobes.loadSym) begin
      cellQ     <= encWord[0];
      shiftQ    <= encWord[SYM_CELLS-1:1];
      lineHighQ <= encWord[SYM_CELLS-1];
    end else if (strobes.shiftCell) begin
      cellQ  <= shiftQ[0];
      shiftQ <= {1'b0, shiftQ[SYM_CELLS-2:1]};
    end else if (strobes.closeEdge) begin
      cellQ     <= ~lineHighQ;
      lineHighQ <= 1'b0;
    end else if (strobes.closeLow) begin
      cellQ <= 1'b0;
    end
  end

endmodule

// File: rtl/bmc_tx_serializer.sv
module bmc_tx_serializer
  import bmc_tx_pkg::*;
#(
  parameter int          PRE_CELLS   = 128,
  parameter int          PAT_W       = 32,
  parameter logic [31:0] PRE_PATTERN = 32'hB4B4_B4B4,
  parameter int          SYM_CELLS   = 10,
  localparam int PAT_IDX_W = $clog2(PAT_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cellTick,
  input  logic                 startPkt,
  input  logic                 symValid,
  input  logic [SYM_CELLS-1:0] symData,
  input  logic                 symLast,
  output logic                 symReady,
  output logic                 txCell,
  output logic                 busy,
  output logic                 pktDone,
  output logic                 underrun
);

  txStrobes_t           strobes;
  logic [PAT_IDX_W-1:0] preIdx;

  bmc_tx_ctrl #(
    .PRE_CELLS(PRE_CELLS),
    .PAT_W(PAT_W),
    .SYM_CELLS(SYM_CELLS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cellTick(cellTick),
    .startPkt(startPkt),
    .symValid(symValid),
    .symLast(symLast),
    .symReady(symReady),
    .strobes(strobes),
    .preIdx(preIdx),
    .busy(busy),
    .pktDone(pktDone),
    .underrun(underrun)
  );

  bmc_tx_datapath #(
    .PAT_W(PAT_W),
    .PRE_PATTERN(PRE_PATTERN),
    .SYM_CELLS(SYM_CELLS)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .preIdx(preIdx),
    .symData(symData),
    .txCell(txCell)
  );

endmodule

// File: rtl/bmc_tx_serializer_chk.sv
module bmc_tx_serializer_chk (
  input logic clk,
  input logic rstN,
  input logic cellTick,
  input logic symReady,
  input logic txCell,
  input logic busy,
  input logic pktDone,
  input logic underrun
);

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    symReady |-> (cellTick && busy)); // R6

  AST_CELL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cellTick |=> $stable(txCell)); // R4

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txCell); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (!busy && $past(busy) == 1'b0)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone); // R8

  AST_UNDERRUN_IN_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> busy); // R9

  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun); // R9

endmodule

bind bmc_tx_serializer bmc_tx_serializer_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .cellTick(cellTick),
  .symReady(symReady),
  .txCell(txCell),
  .busy(busy),
  .pktDone(pktDone),
  .underrun(underrun)
);

// File: tb/bmc_tx_serializer_tb.sv
`timescale 1ns/1ps
module bmc_tx_serializer_tb;

  localparam logic [31:0] TRAIN = 32'hB4B4_B4B4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cellTick = 1'b0;
  logic startPkt = 1'b0;
  logic symValid = 1'b0;
  logic [9:0] symData = '0;
  logic symLast = 1'b0;
  logic symReady, txCell, busy, pktDone, underrun;

  always #4 clk = ~clk;

  bmc_tx_serializer u_dut (
    .clk(clk), .rstN(rstN), .cellTick(cellTick), .startPkt(startPkt),
    .symValid(symValid), .symData(symData), .symLast(symLast),
    .symReady(symReady), .txCell(txCell), .busy(busy),
    .pktDone(pktDone), .underrun(underrun)
  );

  // stimulus state
  logic [10:0] symQ[$];
  logic feedOn = 1'b0;
  int tickDiv = 1;
  int tickCnt = 0;

  // reference model state
  logic cellQ[$];
  int   mPhase = 0;
  logic mOut = 0, mHigh = 0, mLast = 0, mDone = 0, mFinDly = 0, mUnder = 0;
  int   nSym = 0;
  string mTag = "R10";

  int vecCnt = 0;
  int failCnt = 0;
  int cycles = 0;

  // tick generator and symbol source, driven away from the active edge
  always @(negedge clk) begin
    if (tickCnt >= tickDiv - 1) begin
      cellTick <= 1'b1;
      tickCnt <= 0;
    end else begin
      cellTick <= 1'b0;
      tickCnt <= tickCnt + 1;
    end
    symValid <= feedOn && (symQ.size() > 0);
    symData  <= (symQ.size() > 0) ? symQ[0][9:0] : 10'h000;
    symLast  <= (symQ.size() > 0) ? symQ[0][10] : 1'b0;
  end

  // behavioural reference: queue of cells per packet
  always @(posedge clk) begin
    logic [9:0] w;
    if (!rstN) begin
      mPhase = 0; cellQ.delete(); mOut = 0; mHigh = 0; mLast = 0;
      mDone = 0; mFinDly = 0; mUnder = 0; mTag = "R10";
    end else begin
      mDone = mFinDly;
      mFinDly = 0;
      mUnder = 0;
      if (mPhase == 0) begin
        if (startPkt) begin
          mPhase = 1; mLast = 0; nSym = 0; mTag = "R1";
          for (int i = 0; i < 128; i++) cellQ.push_back(TRAIN[i % 32]);
        end
      end else if (cellTick) begin
        case (mPhase)
          1: begin
            mOut = cellQ.pop_front();
            mHigh = mOut;
            if (cellQ.size() == 0) mPhase = 2;
          end
          2: begin
            if (cellQ.size() > 0) begin
              mOut = cellQ.pop_front();
              if (cellQ.size() == 0 && mLast) begin
                cellQ.push_back(!mHigh);
                cellQ.push_back(1'b0);
                mPhase = 3;
              end
            end else if (symValid) begin
              w = symData ^ (mHigh ? 10'h3FF : 10'h000);
              mHigh = w[9];
              mLast = symLast;
              for (int i = 0; i < 10; i++) cellQ.push_back(w[i]);
              mOut = cellQ.pop_front();
              void'(symQ.pop_front());
              mTag = (nSym == 0) ? "R2" : "R3";
              nSym++;
            end else begin
              mUnder = 1;
              mOut = !mHigh;
              cellQ.push_back(1'b0);
              mPhase = 3;
              mTag = "R9";
            end
          end
          3: begin
            if (mTag != "R9") mTag = "R5";
            mOut = cellQ.pop_front();
            if (cellQ.size() == 0) mPhase = 4;
          end
          default: begin
            mPhase = 0;
            mFinDly = 1;
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string name, input logic act, input logic exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs have settled
  always @(negedge clk) begin
    #1;
    cycles++;
    chk(rstN ? mTag : "R10", "txCell (R4 timing)", txCell, mOut);
    chk(rstN ? "R7" : "R10", "busy", busy, rstN && (mPhase != 0));
    chk(rstN ? "R8" : "R10", "pktDone", pktDone, mDone);
    chk(rstN ? "R6" : "R10", "symReady", symReady,
        rstN && (mPhase == 2) && (cellQ.size() == 0) && cellTick);
    chk(rstN ? "R9" : "R10", "underrun", underrun, mUnder);
    if (cycles > 100000) begin
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  task automatic pulseStart();
    @(negedge clk);
    startPkt = 1'b1;
    @(negedge clk);
    startPkt = 1'b0;
  endtask

  task automatic waitEnd();
    @(negedge clk);
    while (!pktDone) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R5: three symbols, mask flips, final line low -> 1,0 close
    tickDiv = 1;
    feedOn = 1'b1;
    symQ.push_back({1'b0, 10'h155});
    symQ.push_back({1'b0, 10'h3A6});
    symQ.push_back({1'b1, 10'h0F2});
    pulseStart();
    waitEnd();

    // R5 R7: sparse ticks, single symbol ending high -> 0,0 close,
    // a stray start mid-packet must be ignored
    tickDiv = 3;
    symQ.push_back({1'b1, 10'h1C3});
    pulseStart();
    repeat (40) @(negedge clk);
    pulseStart();
    waitEnd();

    // R9: underrun after two symbols that carry no last flag
    tickDiv = 2;
    symQ.push_back({1'b0, 10'h2B4});
    symQ.push_back({1'b0, 10'h0CD});
    pulseStart();
    waitEnd();

    // R9: underrun right after the training sequence
    tickDiv = 1;
    feedOn = 1'b0;
    pulseStart();
    waitEnd();

    // R6: data held valid but not offered until needed, tick every cycle
    feedOn = 1'b1;
    symQ.push_back({1'b0, 10'h3FF});
    symQ.push_back({1'b0, 10'h000});
    symQ.push_back({1'b1, 10'h201});
    pulseStart();
    waitEnd();

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule